// File: doc/BRIEF.md
# Two-Thread Priority Dispatch Arbiter

This block chooses, every clock cycle, which of two hardware threads may send an instruction group into a shared dispatch slot. Software gives each thread a 3-bit priority. When both threads can dispatch, the block divides the slots between them according to how far apart those priorities are. Equal priorities alternate. A priority gap of d gives the stronger thread 2^d slots for every slot the weaker thread gets.

Each thread also counts its cache-miss events. Once the count reaches a programmable threshold, that thread is held back and the other thread takes every slot. The hold lasts until a clear pulse arrives. A mode input restricts dispatch to thread 0 alone.

When both threads sit at priority 0, the block enters a low-power state. In that state it grants at most one slot every 32 cycles, and it reports the state on a registered status flag.

Top module: `dual_thread_arbiter`

## Requirements
- R1: After reset, the low-power flag is 0, no thread is throttled, and both priority registers hold level 4 until the next clock edge captures the priority inputs. The first contested grant at equal priority goes to thread 0.
- R2: The grant `gnt_o` has bit 0 for thread 0 and bit 1 for thread 1. It is one-hot or zero. A bit is set only when that thread's ready input is high. With neither thread ready, the grant is zero.
- R3: With equal priorities and both threads eligible, grants alternate between the threads on consecutive cycles.
- R4: With priority difference d > 0 and both threads eligible, the higher-priority thread receives 2^d consecutive grants, then the lower-priority thread receives one. The pattern then repeats.
- R5: A thread at priority 0 is never granted while the other thread is above 0. That other thread receives every grant.
- R6: Each miss pulse raises a thread's miss count. With a nonzero threshold, the thread receives no grant from the cycle after its count reaches the threshold, and the other ready thread receives every grant. A threshold of 0 disables throttling.
- R7: A clear pulse for a thread zeroes that thread's miss count, and the thread can be granted again in the next cycle. A clear wins over a miss pulse arriving in the same cycle.
- R8: While `solo_i` is high, only thread 0 is ever granted, including when only thread 1 is ready.
- R9: Priority inputs are captured on each clock edge. `lowpwr_o` is 1 exactly in the cycles after an edge that captured both priorities at 0.
- R10: In low-power state, a grant may occur only in the first low-power cycle and every 32nd cycle after it. This allows at most one grant in any 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rdy_i | input | 2 | Per-thread ready flag (bit n = thread n) |
| prio0_i | input | 3 | Thread 0 priority, 0 lowest, 7 highest |
| prio1_i | input | 3 | Thread 1 priority |
| miss_i | input | 2 | Per-thread cache-miss event pulse |
| miss_clr_i | input | 2 | Per-thread miss count clear pulse |
| thresh_i | input | 4 | Miss count throttle threshold, 0 disables |
| solo_i | input | 1 | Single-thread mode, thread 0 active |
| gnt_o | output | 2 | One-hot dispatch grant |
| lowpwr_o | output | 1 | Registered low-power status |

## Verification
A share counter holding the wrong value shows up within one slot pattern at the grant port: the weaker thread's slot arrives early or late against the 2^d rhythm. A stuck miss count shows up in the first contested cycle after the threshold or after a clear, because the grant goes to the wrong thread. A wrong low-power window count shows up within 32 cycles, as a grant at the wrong phase or a missing grant. A wrong status register shows up one cycle after the priorities change.

// File: rtl/arb_pkg.sv
// Package: shared constants and types for the dual-thread dispatch arbiter.
// Assumes exactly two threads; bit n of every per-thread vector is thread n.
package arb_pkg;
    localparam int NTHR = 2;
    typedef logic [NTHR-1:0] thr_vec_t;
endpackage

// File: rtl/miss_throttle.sv
// Module: miss_throttle
// Counts cache-miss pulses for one thread and raises a throttle flag once the
// count reaches a nonzero threshold. Assumes a clear pulse outranks a miss
// pulse in the same cycle; the count saturates rather than wrapping.
module miss_throttle #(
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_i,
    input  logic              clr_i,
    input  logic [MISS_W-1:0] thresh_i,
    output logic              throttle_o
);
    localparam logic [MISS_W-1:0] CNT_MAX = {MISS_W{1'b1}};

    logic [MISS_W-1:0] cnt_q;

    // Miss count: clear first, then saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (clr_i)                   cnt_q <= '0;
        else if (miss_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Throttle decision from the stored count.
    always_comb throttle_o = (thresh_i != '0) && (cnt_q >= thresh_i);
endmodule

// File: rtl/lp_ctl.sv
// Module: lp_ctl
// Registers the low-power state from the raw priority inputs and runs the
// dispatch window counter. Assumes the window restarts at zero on each entry.
module lp_ctl #(
    parameter int PRIO_W = 3,
    parameter int LP_WIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRIO_W-1:0] prio0_i,
    input  logic [PRIO_W-1:0] prio1_i,
    output logic              lp_o,
    output logic              slot_ok_o
);
    localparam int WIN_W = (LP_WIN > 1) ? $clog2(LP_WIN) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(LP_WIN - 1);

    logic             lp_q;
    logic [WIN_W-1:0] win_q;

    // Low-power flag: both captured priorities at the lowest level.
    always_ff @(posedge clk) begin
        if (!rst_n) lp_q <= 1'b0;
        else        lp_q <= (prio0_i == '0) && (prio1_i == '0);
    end

    // Window counter: held at zero outside low power, wraps inside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !lp_q)      win_q <= '0;
        else if (win_q == WIN_LAST) win_q <= '0;
        else                      win_q <= win_q + 1'b1;
    end

    // Slot permission: always outside low power, window start inside.
    always_comb begin
        lp_o      = lp_q;
        slot_ok_o = !lp_q || (win_q == '0);
    end
endmodule

// File: rtl/share_ctl.sv
// Module: share_ctl
// Picks the winner between eligible threads. Equal priorities alternate by a
// round-robin pointer; a gap d gives the stronger thread 2^d grants per grant
// to the weaker one. Assumes the eligibility vector already includes ready.
module share_ctl #(
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  arb_pkg::thr_vec_t elig_i,
    input  logic [PRIO_W-1:0] prio0_i,
    input  logic [PRIO_W-1:0] prio1_i,
    output arb_pkg::thr_vec_t gnt_o
);
    localparam int SHARE_W = 2 ** PRIO_W;

    logic               rr_q;      // 0: thread 0 preferred next
    logic [SHARE_W-1:0] run_q;     // consecutive grants to stronger thread
    logic               hi_sel;
    logic [PRIO_W-1:0]  diff;
    logic [SHARE_W:0]   quota;
    logic               uneq;
    arb_pkg::thr_vec_t  gnt;

    // Priority gap and the stronger thread's quota.
    always_comb begin
        uneq   = (prio0_i != prio1_i);
        hi_sel = (prio1_i > prio0_i);
        diff   = hi_sel ? (prio1_i - prio0_i) : (prio0_i - prio1_i);
        quota  = (SHARE_W + 1)'(1) << diff;
    end

    // Winner selection.
    always_comb begin
        unique case (elig_i)
            2'b01: gnt = 2'b01;
            2'b10: gnt = 2'b10;
            2'b11: begin
                if (!uneq)
                    gnt = rr_q ? 2'b10 : 2'b01;
                else if ({1'b0, run_q} < quota)
                    gnt = hi_sel ? 2'b10 : 2'b01;
                else
                    gnt = hi_sel ? 2'b01 : 2'b10;
            end
            default: gnt = 2'b00;
        endcase
        gnt_o = gnt;
    end

    // Round-robin pointer: prefer the thread not granted last.
    always_ff @(posedge clk) begin
        if (!rst_n)        rr_q <= 1'b0;
        else if (gnt != '0) rr_q <= gnt[0];
    end

    // Share run counter: advances on contested unequal grants only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (elig_i == 2'b11 && uneq) begin
            if (gnt[hi_sel]) run_q <= run_q + 1'b1;
            else             run_q <= '0;
        end
    end
endmodule

// File: rtl/dual_thread_arbiter.sv
// Module: dual_thread_arbiter (top)
// Grants one dispatch slot per cycle to one of two threads by priority,
// miss throttling, single-thread mode and a low-power slot limiter.
// Assumes software priority inputs are stable register outputs; they are
// captured each edge. In single-thread mode thread 0 is the active thread.
module dual_thread_arbiter #(
    parameter int PRIO_W = 3,
    parameter int MISS_W = 4,
    parameter int LP_WIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rdy_i,
    input  logic [PRIO_W-1:0] prio0_i,
    input  logic [PRIO_W-1:0] prio1_i,
    input  logic [1:0]        miss_i,
    input  logic [1:0]        miss_clr_i,
    input  logic [MISS_W-1:0] thresh_i,
    input  logic              solo_i,
    output logic [1:0]        gnt_o,
    output logic              lowpwr_o
);
    localparam logic [PRIO_W-1:0] PRIO_MID = PRIO_W'(2 ** (PRIO_W - 1));

    logic [PRIO_W-1:0] p0_q, p1_q;
    arb_pkg::thr_vec_t thr, idle, allow, elig;
    logic              both_low, slot_ok;

    // Priority registers, reset to the middle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p0_q <= PRIO_MID;
            p1_q <= PRIO_MID;
        end else begin
            p0_q <= prio0_i;
            p1_q <= prio1_i;
        end
    end

    // Per-thread miss throttles.
    for (genvar t = 0; t < arb_pkg::NTHR; t++) begin : g_thr
        miss_throttle #(.MISS_W(MISS_W)) u_mt (
            .clk       (clk),
            .rst_n     (rst_n),
            .miss_i    (miss_i[t]),
            .clr_i     (miss_clr_i[t]),
            .thresh_i  (thresh_i),
            .throttle_o(thr[t])
        );
    end

    lp_ctl #(.PRIO_W(PRIO_W), .LP_WIN(LP_WIN)) u_lp (
        .clk      (clk),
        .rst_n    (rst_n),
        .prio0_i  (prio0_i),
        .prio1_i  (prio1_i),
        .lp_o     (lowpwr_o),
        .slot_ok_o(slot_ok)
    );

    // Eligibility: ready, not throttled, not idle, mode and slot permitting.
    always_comb begin
        both_low = (p0_q == '0) && (p1_q == '0);
        idle[0]  = (p0_q == '0) && !both_low;
        idle[1]  = (p1_q == '0) && !both_low;
        allow    = {!solo_i, 1'b1};
        elig     = rdy_i & ~thr & ~idle & allow & {2{slot_ok}};
    end

    share_ctl #(.PRIO_W(PRIO_W)) u_share (
        .clk    (clk),
        .rst_n  (rst_n),
        .elig_i (elig),
        .prio0_i(p0_q),
        .prio1_i(p1_q),
        .gnt_o  (gnt_o)
    );
endmodule

// File: rtl/arb_checker.sv
// Module: arb_checker
// Port-level properties of the dispatch arbiter, bound to the top.
// Assumes the default 32-cycle low-power window.
module arb_checker #(
    parameter int PRIO_W = 3,
    parameter int LP_WIN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        rdy_i,
    input logic [PRIO_W-1:0] prio0_i,
    input logic [PRIO_W-1:0] prio1_i,
    input logic              solo_i,
    input logic [1:0]        gnt_o,
    input logic              lowpwr_o
);
    logic     past_ok;
    int       gap;
    logic     lp_granted;

    // History valid flag: set one cycle after reset release.
    always_ff @(posedge clk) past_ok <= rst_n;

    // Gap since last grant and low-power grant tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap        <= 0;
            lp_granted <= 1'b0;
        end else begin
            gap        <= (gnt_o != '0) ? 0 : ((gap < LP_WIN) ? gap + 1 : gap);
            lp_granted <= lowpwr_o && (lp_granted || gnt_o != '0);
        end
    end

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R2
    gnt_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~rdy_i) == 2'b00);

    // R8
    solo_only_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        solo_i |-> !gnt_o[1]);

    // R9
    lp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> lowpwr_o == ($past(prio0_i) == '0 && $past(prio1_i) == '0));

    // R5
    idle_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(prio0_i) == '0 && $past(prio1_i) != '0) |-> !gnt_o[0]);

    // R10
    lp_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpwr_o && lp_granted && gnt_o != '0) |-> gap >= LP_WIN - 1);
endmodule

bind dual_thread_arbiter arb_checker #(.PRIO_W(PRIO_W), .LP_WIN(LP_WIN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdy_i   (rdy_i),
    .prio0_i (prio0_i),
    .prio1_i (prio1_i),
    .solo_i  (solo_i),
    .gnt_o   (gnt_o),
    .lowpwr_o(lowpwr_o)
);

// File: tb/sim_dual_thread_arbiter.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected grant/flag per cycle, the
// monitor pops and compares at the falling edge.
module sim_dual_thread_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rdy_i = '0;
    logic [2:0] prio0_i = '0;
    logic [2:0] prio1_i = '0;
    logic [1:0] miss_i = '0;
    logic [1:0] miss_clr_i = '0;
    logic [3:0] thresh_i = '0;
    logic       solo_i = 1'b0;
    logic [1:0] gnt_o;
    logic       lowpwr_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    dual_thread_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .rdy_i(rdy_i), .prio0_i(prio0_i),
        .prio1_i(prio1_i), .miss_i(miss_i), .miss_clr_i(miss_clr_i),
        .thresh_i(thresh_i), .solo_i(solo_i), .gnt_o(gnt_o), .lowpwr_o(lowpwr_o)
    );

    // Driver step: queue the expectation for this period, then advance.
    task automatic cyc(input logic [1:0] eg, input logic el, input string tag);
        exp_q.push_back({el, eg});
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare outputs against the oldest expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (gnt_o !== e[1:0] || lowpwr_o !== e[2]) begin
                errors++;
                $display("FAIL %s: gnt=%b lp=%b expected gnt=%b lp=%b",
                         t, gnt_o, lowpwr_o, e[1:0], e[2]);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1; rdy_i = 2'b11;
        // R1: priorities still at reset level 4, thread 0 first
        cyc(2'b01, 1'b0, "R1");
        // R9: both zero captured -> low power; R10 first lp slot grants
        cyc(2'b10, 1'b1, "R9");
        prio0_i = 3'd4; prio1_i = 3'd4;
        cyc(2'b00, 1'b1, "R10");
        // R3: alternate at equal priority
        cyc(2'b01, 1'b0, "R3");
        cyc(2'b10, 1'b0, "R3");
        cyc(2'b01, 1'b0, "R3");
        cyc(2'b10, 1'b0, "R3");
        // R2: nobody ready
        rdy_i = 2'b00;
        cyc(2'b00, 1'b0, "R2");
        rdy_i = 2'b10;
        cyc(2'b10, 1'b0, "R2");
        // R6: three misses on thread 0 with threshold 3
        thresh_i = 4'd3; rdy_i = 2'b00; miss_i = 2'b01;
        for (int i = 0; i < 3; i++) cyc(2'b00, 1'b0, "R6");
        miss_i = 2'b00; rdy_i = 2'b11;
        for (int i = 0; i < 3; i++) cyc(2'b10, 1'b0, "R6");
        // R7: clear wins over a same-cycle miss
        rdy_i = 2'b00; miss_i = 2'b01; miss_clr_i = 2'b01;
        cyc(2'b00, 1'b0, "R7");
        miss_i = 2'b00; miss_clr_i = 2'b00; rdy_i = 2'b11;
        cyc(2'b01, 1'b0, "R7");
        cyc(2'b10, 1'b0, "R7");
        // R6: threshold 0 disables throttling
        thresh_i = 4'd0; rdy_i = 2'b00; miss_i = 2'b01;
        for (int i = 0; i < 4; i++) cyc(2'b00, 1'b0, "R6");
        miss_i = 2'b00; rdy_i = 2'b01;
        cyc(2'b01, 1'b0, "R6");
        rdy_i = 2'b00; miss_clr_i = 2'b01;
        cyc(2'b00, 1'b0, "R7");
        miss_clr_i = 2'b00;
        // R4: d=2, thread 0 stronger
        prio0_i = 3'd6; prio1_i = 3'd4;
        cyc(2'b00, 1'b0, "R4");
        rdy_i = 2'b11;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 4; i++) cyc(2'b01, 1'b0, "R4");
            cyc(2'b10, 1'b0, "R4");
        end
        // R4: d=1, thread 1 stronger
        rdy_i = 2'b00; prio0_i = 3'd3; prio1_i = 3'd4;
        cyc(2'b00, 1'b0, "R4");
        rdy_i = 2'b11;
        for (int k = 0; k < 2; k++) begin
            cyc(2'b10, 1'b0, "R4");
            cyc(2'b10, 1'b0, "R4");
            cyc(2'b01, 1'b0, "R4");
        end
        // R5: thread 0 idle at level 0
        rdy_i = 2'b00; prio0_i = 3'd0; prio1_i = 3'd5;
        cyc(2'b00, 1'b0, "R5");
        rdy_i = 2'b11;
        for (int i = 0; i < 3; i++) cyc(2'b10, 1'b0, "R5");
        // R8: single-thread mode
        rdy_i = 2'b00; prio0_i = 3'd4; prio1_i = 3'd4; solo_i = 1'b1;
        cyc(2'b00, 1'b0, "R8");
        rdy_i = 2'b11;
        for (int i = 0; i < 3; i++) cyc(2'b01, 1'b0, "R8");
        rdy_i = 2'b10;
        cyc(2'b00, 1'b0, "R8");
        solo_i = 1'b0;
        // R10: low-power slot every 32 cycles
        rdy_i = 2'b00; prio0_i = 3'd0; prio1_i = 3'd0;
        cyc(2'b00, 1'b0, "R9");
        rdy_i = 2'b01;
        for (int i = 0; i < 65; i++)
            cyc((i % 32 == 0) ? 2'b01 : 2'b00, 1'b1, "R10");
        // R9: leave low power
        rdy_i = 2'b00; prio0_i = 3'd4; prio1_i = 3'd4;
        cyc(2'b00, 1'b1, "R9");
        rdy_i = 2'b01;
        cyc(2'b01, 1'b0, "R9");
        @(negedge clk);
        #1;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule